// File: doc/BRIEF.md
# Scratchpad Port Time-Slot Arbiter

This block shares the one port of a 128-bit-wide, single-ported scratchpad SRAM between two users: the processor core's path for instruction fetches, loads and stores, and a DMA engine that moves whole 128-byte blocks between the scratchpad and the global address space. The DMA source or destination may be system memory or another core's scratchpad. The scratchpad is a software-managed store rather than a cache, so the block holds no tags, makes no hit or miss decision and keeps no coherence state.

Arbitration does not use priority or round-robin. A free-running frame of eight cycles sets a fixed schedule. The last cycle of each frame is reserved for the DMA engine, and the other seven belong to the core path. A DMA block takes eight 16-byte beats, one per reserved cycle, so a full block completes in eight frames. When the DMA engine has nothing pending, the reserved cycle falls back to the core. A core request that meets an occupied reserved cycle waits exactly one cycle.

Both requesters see the SRAM read data directly. The arbiter returns a per-requester valid strobe one cycle after each granted read, which matches the SRAM's one-cycle read latency.

Top module: `ls_port_arbiter`

## Requirements
- R1: After reset release, the cycles are numbered from 0, and a DMA grant can occur only in cycles whose number modulo 8 equals 7 (the reserved cycle).
- R2: In every cycle that is not reserved, `core_gnt` equals `core_req` and `dma_gnt` is 0.
- R3: In a reserved cycle with `dma_req` high, `dma_gnt` is 1, `core_gnt` is 0, and the SRAM port carries `dma_we` and `dma_wdata`.
- R4: In a reserved cycle with `dma_req` low, the core is granted whenever `core_req` is high.
- R5: A core request that is refused in a reserved cycle and is still held in the next cycle is granted in that next cycle.
- R6: A DMA beat drives `sram_addr` = {`dma_blk`, beat index}, where the beat index (3 bits, least significant) starts at 0 after reset and increases by one on each DMA grant. It holds its value across reserved cycles without a DMA request.
- R7: `dma_done` is high for exactly the one cycle after the grant of beat index 7, and the next DMA grant uses beat index 0.
- R8: A core access drives `sram_addr` = `core_addr` >> 4, so the low four byte-address bits have no effect. `sram_we` = `core_we` and `sram_wdata` = `core_wdata`.
- R9: At most one grant is high per cycle, and `sram_en` is high exactly when a grant is high. With no grant, `sram_we`, `sram_addr` and `sram_wdata` are 0.
- R10: `core_rvalid` (respectively `dma_rvalid`) is high in the cycle after a granted access by that requester with its write-enable low, and is low otherwise.
- R11: While reset is asserted and all requests are low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| core_req | input | 1 | Core path requests the port this cycle |
| core_we | input | 1 | Core access is a store (1) or fetch/load (0) |
| core_addr | input | 16 | Core byte address; low 4 bits ignored |
| core_wdata | input | 128 | Core store data |
| core_gnt | output | 1 | Core access performed this cycle |
| core_rvalid | output | 1 | SRAM read data belongs to the core this cycle |
| dma_req | input | 1 | DMA engine has a beat pending |
| dma_we | input | 1 | DMA beat writes (1) or reads (0) the scratchpad |
| dma_blk | input | 9 | 128-byte block index in the scratchpad |
| dma_wdata | input | 128 | DMA write beat data |
| dma_gnt | output | 1 | DMA beat performed this cycle |
| dma_rvalid | output | 1 | SRAM read data belongs to the DMA engine this cycle |
| dma_done | output | 1 | One-cycle pulse after the last beat of a block |
| sram_en | output | 1 | SRAM port enable |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 12 | SRAM line index (16-byte lines) |
| sram_wdata | output | 128 | SRAM write data |

## Verification
A wrong frame counter moves DMA grants away from every eighth cycle, or breaks the one-cycle stall. The fault shows at `dma_gnt` and `core_gnt` within one frame of the first DMA request. A wrong beat counter shows in the low three bits of `sram_addr` on the next DMA grant, and a wrong end-of-block decision shows at `dma_done` no later than the eighth beat. A stale read-owner flop shows at the valid strobes one cycle after the faulty grant. The reference model steps cycle by cycle and is compared on every clock, so each of these faults is caught in the cycle it first shows at the ports.

// File: rtl/ls_arb_pkg.sv
package ls_arb_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_CORE = 2'd1,
    OWN_DMA  = 2'd2
  } port_owner_e;
endpackage

// File: rtl/ls_slot_timer.sv
// Free-running frame counter; flags the reserved (last) slot of each frame.
module ls_slot_timer #(
  parameter int SLOTS = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic resv_slot
);
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;

  always_comb begin
    if (slot_q == LAST_SLOT) slot_d = '0;
    else                     slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign resv_slot = (slot_q == LAST_SLOT);
endmodule

// File: rtl/ls_beat_ctr.sv
// Counts granted DMA beats inside a block and flags the block end.
module ls_beat_ctr #(
  parameter int BEATS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat_adv,
  output logic [$clog2(BEATS)-1:0]  beat_idx,
  output logic                      blk_done
);
  localparam int BEAT_W = $clog2(BEATS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              done_q, done_d;
  logic              at_last;

  assign at_last = (beat_q == LAST_BEAT);

  always_comb begin
    beat_d = beat_q;
    done_d = 1'b0;
    if (beat_adv) begin
      done_d = at_last;
      beat_d = at_last ? '0 : beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_adv) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign beat_idx = beat_q;
  assign blk_done = done_q;
endmodule

// File: rtl/ls_port_mux.sv
// Decides the port owner for this cycle and steers the SRAM port.
module ls_port_mux
  import ls_arb_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LINE_W = 12
) (
  input  logic              resv_slot,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [LINE_W-1:0] core_line,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [LINE_W-1:0] dma_line,
  input  logic [DATA_W-1:0] dma_wdata,
  output port_owner_e       owner,
  output logic              core_gnt,
  output logic              dma_gnt,
  output logic              sram_en,
  output logic              sram_we,
  output logic [LINE_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata
);
  always_comb begin
    if (resv_slot && dma_req) owner = OWN_DMA;
    else if (core_req)        owner = OWN_CORE;
    else                      owner = OWN_IDLE;
  end

  always_comb begin
    core_gnt   = 1'b0;
    dma_gnt    = 1'b0;
    sram_en    = 1'b0;
    sram_we    = 1'b0;
    sram_addr  = '0;
    sram_wdata = '0;
    unique case (owner)
      OWN_DMA: begin
        dma_gnt    = 1'b1;
        sram_en    = 1'b1;
        sram_we    = dma_we;
        sram_addr  = dma_line;
        sram_wdata = dma_wdata;
      end
      OWN_CORE: begin
        core_gnt   = 1'b1;
        sram_en    = 1'b1;
        sram_we    = core_we;
        sram_addr  = core_line;
        sram_wdata = core_wdata;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ls_port_arbiter.sv
module ls_port_arbiter
  import ls_arb_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 128,
  parameter int SLOTS       = 8,
  localparam int OFS_W      = $clog2(DATA_W / 8),
  localparam int BEATS      = BLOCK_BYTES / (DATA_W / 8),
  localparam int BEAT_W     = $clog2(BEATS),
  localparam int LINE_W     = ADDR_W - OFS_W,
  localparam int BLK_W      = LINE_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_req,
  input  logic              core_we,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  output logic              core_gnt,
  output logic              core_rvalid,
  input  logic              dma_req,
  input  logic              dma_we,
  input  logic [BLK_W-1:0]  dma_blk,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic              dma_gnt,
  output logic              dma_rvalid,
  output logic              dma_done,
  output logic              sram_en,
  output logic              sram_we,
  output logic [LINE_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata
);
  logic              resv_slot;
  logic [BEAT_W-1:0] beat_idx;
  logic [LINE_W-1:0] core_line, dma_line;
  port_owner_e       owner;
  logic              crv_q, crv_d, drv_q, drv_d;
  logic              unused_ofs;

  assign core_line  = core_addr[ADDR_W-1:OFS_W];
  assign unused_ofs = ^core_addr[OFS_W-1:0];
  assign dma_line   = {dma_blk, beat_idx};

  ls_slot_timer #(.SLOTS(SLOTS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .resv_slot (resv_slot)
  );

  ls_port_mux #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_mux (
    .resv_slot  (resv_slot),
    .core_req   (core_req),
    .core_we    (core_we),
    .core_line  (core_line),
    .core_wdata (core_wdata),
    .dma_req    (dma_req),
    .dma_we     (dma_we),
    .dma_line   (dma_line),
    .dma_wdata  (dma_wdata),
    .owner      (owner),
    .core_gnt   (core_gnt),
    .dma_gnt    (dma_gnt),
    .sram_en    (sram_en),
    .sram_we    (sram_we),
    .sram_addr  (sram_addr),
    .sram_wdata (sram_wdata)
  );

  ls_beat_ctr #(.BEATS(BEATS)) u_beats (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_adv (dma_gnt),
    .beat_idx (beat_idx),
    .blk_done (dma_done)
  );

  // Read-return owner: SRAM answers one cycle after the granted read.
  always_comb begin
    crv_d = (owner == OWN_CORE) && !core_we;
    drv_d = (owner == OWN_DMA)  && !dma_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crv_q <= 1'b0;
      drv_q <= 1'b0;
    end else begin
      crv_q <= crv_d;
      drv_q <= drv_d;
    end
  end

  assign core_rvalid = crv_q;
  assign dma_rvalid  = drv_q;
endmodule

// File: rtl/ls_arb_checker.sv
module ls_arb_checker #(
  parameter int SLOTS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic core_req,
  input logic core_we,
  input logic core_gnt,
  input logic core_rvalid,
  input logic dma_req,
  input logic dma_we,
  input logic dma_gnt,
  input logic dma_rvalid,
  input logic dma_done,
  input logic sram_en
);
  localparam int PH_W = (SLOTS > 1) ? $clog2(SLOTS) + 1 : 2;
  logic [PH_W-1:0] ck_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ck_phase <= '0;
    else if (ck_phase == PH_W'(SLOTS-1)) ck_phase <= '0;
    else                                 ck_phase <= ck_phase + 1'b1;
  end

  p_dma_in_resv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |-> (ck_phase == PH_W'(SLOTS-1)));

  p_core_free_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !dma_gnt) |-> core_gnt);

  p_dma_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_gnt |-> dma_req);

  p_stall_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && !core_gnt) |=> (!core_req || core_gnt));

  p_done_after_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |-> $past(dma_gnt));

  p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_gnt, dma_gnt}) && (sram_en == (core_gnt || dma_gnt)));

  p_core_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    core_rvalid |-> $past(core_gnt && !core_we));

  p_dma_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rvalid |-> $past(dma_gnt && !dma_we));
endmodule

bind ls_port_arbiter ls_arb_checker #(.SLOTS(SLOTS)) u_arb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_req    (core_req),
  .core_we     (core_we),
  .core_gnt    (core_gnt),
  .core_rvalid (core_rvalid),
  .dma_req     (dma_req),
  .dma_we      (dma_we),
  .dma_gnt     (dma_gnt),
  .dma_rvalid  (dma_rvalid),
  .dma_done    (dma_done),
  .sram_en     (sram_en)
);

// File: tb/tb_ls_port_arbiter.sv
`timescale 1ns/1ps
module tb_ls_port_arbiter;
  localparam int DW = 128;
  localparam int AW = 16;
  localparam int LW = 12;
  localparam int BW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          core_req, core_we, dma_req, dma_we;
  logic [AW-1:0] core_addr;
  logic [DW-1:0] core_wdata, dma_wdata;
  logic [BW-1:0] dma_blk;
  logic          core_gnt, core_rvalid, dma_gnt, dma_rvalid, dma_done;
  logic          sram_en, sram_we;
  logic [LW-1:0] sram_addr;
  logic [DW-1:0] sram_wdata;

  always #2 clk = ~clk;

  ls_port_arbiter dut (
    .clk(clk), .rst_n(rst_n),
    .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
    .core_wdata(core_wdata), .core_gnt(core_gnt), .core_rvalid(core_rvalid),
    .dma_req(dma_req), .dma_we(dma_we), .dma_blk(dma_blk),
    .dma_wdata(dma_wdata), .dma_gnt(dma_gnt), .dma_rvalid(dma_rvalid),
    .dma_done(dma_done), .sram_en(sram_en), .sram_we(sram_we),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference state
  int cyc, mbeat, blocks;
  bit m_done, m_crv, m_drv, stalled;

  task automatic compare_cycle();
    bit resv, e_dg, e_cg, e_we;
    logic [LW-1:0] e_addr;
    logic [DW-1:0] e_wd;
    resv = (cyc % 8) == 7;
    e_dg = resv && dma_req;
    e_cg = core_req && !e_dg;
    e_we = e_dg ? dma_we : (e_cg ? core_we : 1'b0);
    e_addr = e_dg ? LW'({dma_blk, 3'(mbeat)}) : (e_cg ? LW'(core_addr >> 4) : '0);
    e_wd = e_dg ? dma_wdata : (e_cg ? core_wdata : '0);
    chk(dma_gnt == e_dg, resv ? "R3 dma_gnt" : "R1 dma_gnt", dma_gnt, e_dg);
    chk(core_gnt == e_cg, resv ? (dma_req ? "R3 core_gnt" : "R4 core_gnt") : "R2 core_gnt",
        core_gnt, e_cg);
    if (stalled && core_req) chk(core_gnt == 1'b1, "R5 stalled core regrant", core_gnt, 1);
    chk(sram_en == (e_dg || e_cg), "R9 sram_en", sram_en, e_dg || e_cg);
    chk(sram_we == e_we, "R9 sram_we", sram_we, e_we);
    chk(sram_addr == e_addr, e_dg ? "R6 dma addr" : "R8 core addr", sram_addr, e_addr);
    chk(sram_wdata == e_wd, e_dg ? "R3 dma wdata" : "R8 core wdata", sram_wdata, e_wd);
    chk(dma_done == m_done, "R7 dma_done", dma_done, m_done);
    chk(core_rvalid == m_crv, "R10 core_rvalid", core_rvalid, m_crv);
    chk(dma_rvalid == m_drv, "R10 dma_rvalid", dma_rvalid, m_drv);
    @(posedge clk);
    m_done = e_dg && (mbeat == 7);
    if (e_dg) mbeat = (mbeat + 1) % 8;
    m_crv = e_cg && !core_we;
    m_drv = e_dg && !dma_we;
    stalled = core_req && !e_cg;
    cyc++;
  endtask

  task automatic drive(input bit cr, input bit cw, input bit dr, input bit dwe);
    core_req   = cr;
    core_we    = cw;
    core_addr  = AW'($urandom);
    core_wdata = {$urandom, $urandom, $urandom, $urandom};
    dma_req    = dr;
    dma_we     = dwe;
    dma_wdata  = {$urandom, $urandom, $urandom, $urandom};
  endtask

  initial begin
    rst_n = 1'b0;
    core_req = 0; core_we = 0; core_addr = '0; core_wdata = '0;
    dma_req = 0; dma_we = 0; dma_blk = '0; dma_wdata = '0;
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    chk({core_gnt, core_rvalid, dma_gnt, dma_rvalid, dma_done, sram_en, sram_we} == '0,
        "R11 reset flags", {core_gnt, dma_gnt, dma_done, sram_en}, 0);
    chk(sram_addr == '0 && sram_wdata == '0, "R11 reset bus", sram_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0; mbeat = 0; m_done = 0; m_crv = 0; m_drv = 0; stalled = 0; blocks = 0;

    // Phase 1: core alone, low address nibble set (R2, R4, R8)
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, i[0], 1'b0, 1'b0);
      core_addr[3:0] = 4'hF;
      #1 compare_cycle();
      @(negedge clk);
    end
    // Phase 2: both request continuously for two full blocks (R3, R5, R6, R7)
    dma_blk = 9'h0A5;
    for (int i = 0; i < 140; i++) begin
      drive(1'b1, 1'b0, 1'b1, i > 70);
      #1 compare_cycle();
      if (m_done) blocks++;
      @(negedge clk);
    end
    chk(blocks == 2, "R7 block count", blocks, 2);
    // Phase 3: mixed random traffic with gaps in DMA requests
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) dma_blk = BW'($urandom);
      drive(($urandom % 4) != 0, $urandom % 2, ($urandom % 3) == 0, $urandom % 2);
      #1 compare_cycle();
      @(negedge clk);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule